// File: doc/BRIEF.md
# Display Buffer Scan Address Generator

This block produces the memory read addresses that a display refresh engine uses to fetch pixel data from a graphics aperture of up to 4 MB. It keeps three address streams: the uncompressed frame buffer, the compressed line buffer and the cursor pattern. A small register port programs the start offsets, a line step in DWORDs and a per-line fetch budget in DWORDs for each of the two line-organised buffers. All addresses are byte offsets relative to the aperture base.

The video timing logic supplies a frame pulse and a line pulse. On the frame pulse each stream reloads from its programmed start. On each later line pulse the two line-organised streams move their line pointer forward by the line step. Within a line, each fetch request advances the address by one DWORD until the line budget is used up. The cursor stream walks one linear block and ignores line pulses. The upper part of the frame buffer start is double-buffered so that panning takes effect on a frame boundary, while its 4-bit pixel offset is passed straight through. A nonzero frame buffer start raises a flag that turns the compression path off.

Top module: `disp_scan_agen`

## Requirements
- R1: Register reads are combinational on `reg_addr`: index 0 frame buffer start (bits 21:0), 1 compressed start (21:4 stored, 3:0 read 0), 2 cursor start (21:2 stored, 1:0 read 0), 3 line steps (frame buffer step 9:0, compressed step 21:12), 4 line budgets (same field positions as index 3). All other bits and indexes 5 to 7 read 0.
- R2: A write to bits 21:4 of the frame buffer start does not move `fb_addr` until the next `frame_start`, after which `fb_addr` equals the new value with bits 3:0 zero.
- R3: Bits 3:0 of a frame buffer start write appear on `fb_pix_off` in the cycle after the write, with no frame pulse.
- R4: On `line_start` without `frame_start`, a stream's line pointer grows by its step times 4 bytes and its in-line index returns to 0.
- R5: Each accepted request (`*_req` high while `*_done` is low) advances the stream address by 4 in the next cycle; `*_done` is high once the line budget is used, and requests while it is high leave the address unchanged.
- R6: The compressed buffer start is 16-byte aligned: bits 3:0 of its write are discarded.
- R7: The cursor address is DWORD aligned, reloads from its start on `frame_start`, grows by 4 on each `cur_req` and is not changed by `line_start`.
- R8: `comp_off` is high exactly when the programmed frame buffer start (bits 21:0) is nonzero.
- R9: All address arithmetic wraps modulo 2^22 bytes.
- R10: After reset all registers are zero, all addresses are 0, `fb_pix_off` and `comp_off` are 0 and both `*_done` flags are high.
- R11: When `frame_start` and `line_start` are high in the same cycle, the frame reload wins and the line pointer takes the start offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| frame_start | input | 1 | One-cycle frame pulse |
| line_start | input | 1 | One-cycle line pulse |
| fb_req | input | 1 | Frame buffer fetch request |
| fb_addr | output | 22 | Frame buffer byte address to fetch |
| fb_pix_off | output | 4 | Frame buffer pixel offset |
| fb_done | output | 1 | Frame buffer line budget used up |
| cb_req | input | 1 | Compressed buffer fetch request |
| cb_addr | output | 22 | Compressed buffer byte address to fetch |
| cb_done | output | 1 | Compressed buffer line budget used up |
| cur_req | input | 1 | Cursor fetch request |
| cur_addr | output | 22 | Cursor byte address to fetch |
| comp_off | output | 1 | Compression path disable |

## Verification
The assertions check on every cycle the per-request DWORD step and the hold while a line is exhausted, the cursor step and its alignment, the immediate pixel offset, the zero reserved read bits and alignment of the frame reload. Only the bench scenarios can show the delayed effect of a frame buffer start write across a frame boundary, the exact line step sums including wrap past 4 MB, the priority of a frame pulse over a coincident line pulse and the cursor's indifference to line pulses, since these need expected values built from several earlier writes.

// File: rtl/scan_agen_pkg.sv
package scan_agen_pkg;
  localparam int unsigned AW    = 22;  // aperture byte address width (4 MB)
  localparam int unsigned STEPW = 10;  // line step field width in DWORDs
  localparam int unsigned CNTW  = 10;  // line budget field width in DWORDs
  localparam int unsigned RAW   = 3;   // register index width
  localparam int unsigned DATW  = 32;  // register data width
  localparam int unsigned PIXW  = 4;   // pixel offset width
  localparam int unsigned HI_LSB = 12; // compressed field position in step/budget registers
  localparam int unsigned NSTRM = 2;   // line-organised streams

  typedef enum logic [RAW-1:0] {
    RG_FBST  = 3'd0,
    RG_CBST  = 3'd1,
    RG_CURST = 3'd2,
    RG_STEP  = 3'd3,
    RG_BUDG  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/scan_agen_regs.sv
module scan_agen_regs
  import scan_agen_pkg::*;
#(
  parameter int unsigned A_W = AW,
  parameter int unsigned S_W = STEPW,
  parameter int unsigned C_W = CNTW,
  parameter int unsigned P_W = PIXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RAW-1:0]  addr,
  input  logic [DATW-1:0] wdata,
  output logic [DATW-1:0] rdata,
  output logic [A_W-1:0]  fb_base,
  output logic [P_W-1:0]  pix_off,
  output logic [A_W-1:0]  cb_base,
  output logic [A_W-1:0]  cur_base,
  output logic [S_W-1:0]  fb_step,
  output logic [S_W-1:0]  cb_step,
  output logic [C_W-1:0]  fb_budget,
  output logic [C_W-1:0]  cb_budget,
  output logic            comp_off
);
  localparam int unsigned CBAL = 4;  // compressed start alignment bits
  localparam int unsigned CUAL = 2;  // cursor start alignment bits

  logic [A_W-1:P_W]  fbh_q, fbh_d;
  logic [P_W-1:0]    pix_q, pix_d;
  logic [A_W-1:CBAL] cbh_q, cbh_d;
  logic [A_W-1:CUAL] cuh_q, cuh_d;
  logic [S_W-1:0]    fbs_q, fbs_d, cbs_q, cbs_d;
  logic [C_W-1:0]    fbc_q, fbc_d, cbc_q, cbc_d;

  logic wr_fb, wr_cb, wr_cu, wr_st, wr_bg;

  // write decode
  always_comb begin
    wr_fb = we && (addr == RG_FBST);
    wr_cb = we && (addr == RG_CBST);
    wr_cu = we && (addr == RG_CURST);
    wr_st = we && (addr == RG_STEP);
    wr_bg = we && (addr == RG_BUDG);
  end

  // next-state values
  always_comb begin
    fbh_d = wdata[A_W-1:P_W];
    pix_d = wdata[P_W-1:0];
    cbh_d = wdata[A_W-1:CBAL];
    cuh_d = wdata[A_W-1:CUAL];
    fbs_d = wdata[S_W-1:0];
    cbs_d = wdata[HI_LSB+S_W-1:HI_LSB];
    fbc_d = wdata[C_W-1:0];
    cbc_d = wdata[HI_LSB+C_W-1:HI_LSB];
  end

  // register stage with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbh_q <= '0;
      pix_q <= '0;
      cbh_q <= '0;
      cuh_q <= '0;
      fbs_q <= '0;
      cbs_q <= '0;
      fbc_q <= '0;
      cbc_q <= '0;
    end else begin
      if (wr_fb) begin
        fbh_q <= fbh_d;
        pix_q <= pix_d;
      end
      if (wr_cb) cbh_q <= cbh_d;
      if (wr_cu) cuh_q <= cuh_d;
      if (wr_st) begin
        fbs_q <= fbs_d;
        cbs_q <= cbs_d;
      end
      if (wr_bg) begin
        fbc_q <= fbc_d;
        cbc_q <= cbc_d;
      end
    end
  end

  // read mux, reserved bits zero
  always_comb begin
    rdata = '0;
    unique case (addr)
      RG_FBST:  rdata[A_W-1:0] = {fbh_q, pix_q};
      RG_CBST:  rdata[A_W-1:0] = {cbh_q, {CBAL{1'b0}}};
      RG_CURST: rdata[A_W-1:0] = {cuh_q, {CUAL{1'b0}}};
      RG_STEP: begin
        rdata[S_W-1:0]               = fbs_q;
        rdata[HI_LSB+S_W-1:HI_LSB]   = cbs_q;
      end
      RG_BUDG: begin
        rdata[C_W-1:0]               = fbc_q;
        rdata[HI_LSB+C_W-1:HI_LSB]   = cbc_q;
      end
      default: rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DATW-1:A_W]};

  assign fb_base   = {fbh_q, {P_W{1'b0}}};
  assign pix_off   = pix_q;
  assign cb_base   = {cbh_q, {CBAL{1'b0}}};
  assign cur_base  = {cuh_q, {CUAL{1'b0}}};
  assign fb_step   = fbs_q;
  assign cb_step   = cbs_q;
  assign fb_budget = fbc_q;
  assign cb_budget = cbc_q;
  assign comp_off  = (|fbh_q) | (|pix_q);
endmodule

// File: rtl/scan_agen_line.sv
module scan_agen_line
  import scan_agen_pkg::*;
#(
  parameter int unsigned A_W = AW,
  parameter int unsigned S_W = STEPW,
  parameter int unsigned C_W = CNTW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           line_start,
  input  logic           req,
  input  logic [A_W-1:0] base,
  input  logic [S_W-1:0] step,
  input  logic [C_W-1:0] budget,
  output logic [A_W-1:0] addr,
  output logic           done
);
  logic [A_W-1:0] line_q, line_d;
  logic [C_W-1:0] idx_q, idx_d;
  logic           line_en, idx_en;
  logic [A_W-1:0] step_bytes, idx_bytes;

  always_comb begin
    step_bytes = A_W'({step, 2'b00});
    idx_bytes  = A_W'({idx_q, 2'b00});
    done       = (idx_q >= budget);
  end

  // next-state: frame reload beats line advance beats fetch
  always_comb begin
    line_d  = line_q;
    idx_d   = idx_q;
    line_en = 1'b0;
    idx_en  = 1'b0;
    if (frame_start) begin
      line_d  = base;
      idx_d   = '0;
      line_en = 1'b1;
      idx_en  = 1'b1;
    end else if (line_start) begin
      line_d  = line_q + step_bytes;
      idx_d   = '0;
      line_en = 1'b1;
      idx_en  = 1'b1;
    end else if (req && !done) begin
      idx_d  = idx_q + 1'b1;
      idx_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      idx_q  <= '0;
    end else begin
      if (line_en) line_q <= line_d;
      if (idx_en)  idx_q  <= idx_d;
    end
  end

  assign addr = line_q + idx_bytes;
endmodule

// File: rtl/scan_agen_curs.sv
module scan_agen_curs
  import scan_agen_pkg::*;
#(
  parameter int unsigned A_W = AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           req,
  input  logic [A_W-1:0] base,
  output logic [A_W-1:0] addr
);
  localparam logic [A_W-1:0] DWORD_BYTES = A_W'(4);

  logic [A_W-1:0] ptr_q, ptr_d;
  logic           ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (frame_start) begin
      ptr_d  = base;
      ptr_en = 1'b1;
    end else if (req) begin
      ptr_d  = ptr_q + DWORD_BYTES;
      ptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign addr = ptr_q;
endmodule

// File: rtl/disp_scan_agen.sv
module disp_scan_agen
  import scan_agen_pkg::*;
#(
  parameter int unsigned ADDR_W = AW,
  parameter int unsigned STEP_W = STEPW,
  parameter int unsigned CNT_W  = CNTW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [DATW-1:0]   reg_wdata,
  output logic [DATW-1:0]   reg_rdata,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              fb_req,
  output logic [ADDR_W-1:0] fb_addr,
  output logic [PIXW-1:0]   fb_pix_off,
  output logic              fb_done,
  input  logic              cb_req,
  output logic [ADDR_W-1:0] cb_addr,
  output logic              cb_done,
  input  logic              cur_req,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              comp_off
);
  logic [ADDR_W-1:0] fb_base, cb_base, cur_base;
  logic [STEP_W-1:0] fb_step, cb_step;
  logic [CNT_W-1:0]  fb_budget, cb_budget;

  logic [ADDR_W-1:0] s_base   [NSTRM];
  logic [STEP_W-1:0] s_step   [NSTRM];
  logic [CNT_W-1:0]  s_budget [NSTRM];
  logic              s_req    [NSTRM];
  logic [ADDR_W-1:0] s_addr   [NSTRM];
  logic              s_done   [NSTRM];

  scan_agen_regs #(
    .A_W(ADDR_W), .S_W(STEP_W), .C_W(CNT_W), .P_W(PIXW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .fb_base   (fb_base),
    .pix_off   (fb_pix_off),
    .cb_base   (cb_base),
    .cur_base  (cur_base),
    .fb_step   (fb_step),
    .cb_step   (cb_step),
    .fb_budget (fb_budget),
    .cb_budget (cb_budget),
    .comp_off  (comp_off)
  );

  // stream 0: frame buffer, stream 1: compressed buffer
  assign s_base[0]   = fb_base;
  assign s_step[0]   = fb_step;
  assign s_budget[0] = fb_budget;
  assign s_req[0]    = fb_req;
  assign s_base[1]   = cb_base;
  assign s_step[1]   = cb_step;
  assign s_budget[1] = cb_budget;
  assign s_req[1]    = cb_req;

  for (genvar g = 0; g < NSTRM; g++) begin : g_strm
    scan_agen_line #(
      .A_W(ADDR_W), .S_W(STEP_W), .C_W(CNT_W)
    ) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .line_start  (line_start),
      .req         (s_req[g]),
      .base        (s_base[g]),
      .step        (s_step[g]),
      .budget      (s_budget[g]),
      .addr        (s_addr[g]),
      .done        (s_done[g])
    );
  end

  assign fb_addr = s_addr[0];
  assign fb_done = s_done[0];
  assign cb_addr = s_addr[1];
  assign cb_done = s_done[1];

  scan_agen_curs #(.A_W(ADDR_W)) u_curs (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .req         (cur_req),
    .base        (cur_base),
    .addr        (cur_addr)
  );
endmodule

// File: rtl/scan_agen_chk.sv
module scan_agen_chk
  import scan_agen_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [RAW-1:0]  reg_addr,
  input logic [DATW-1:0] reg_wdata,
  input logic [DATW-1:0] reg_rdata,
  input logic            frame_start,
  input logic            line_start,
  input logic            fb_req,
  input logic [AW-1:0]   fb_addr,
  input logic [PIXW-1:0] fb_pix_off,
  input logic            fb_done,
  input logic            cb_req,
  input logic [AW-1:0]   cb_addr,
  input logic            cb_done,
  input logic            cur_req,
  input logic [AW-1:0]   cur_addr,
  input logic            comp_off
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATW-1:AW] == '0);

  // R6
  cb_align_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RG_CBST) |-> (reg_rdata[3:0] == 4'h0));

  // R3
  pix_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RG_FBST) |=> (fb_pix_off == $past(reg_wdata[PIXW-1:0])));

  // R8
  comp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RG_FBST && reg_wdata[AW-1:0] == '0) |=> !comp_off);

  // R5
  fb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_req && !fb_done && !frame_start && !line_start) |=> (fb_addr == $past(fb_addr) + AW'(4)));

  // R5
  fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_req && fb_done && !frame_start && !line_start) |=> $stable(fb_addr));

  // R5
  cb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_req && !cb_done && !frame_start && !line_start) |=> (cb_addr == $past(cb_addr) + AW'(4)));

  // R7
  cur_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_addr[1:0] == 2'b00);

  // R7
  cur_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_req && !frame_start) |=> (cur_addr == $past(cur_addr) + AW'(4)));

  // R7
  cur_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && !cur_req) |=> $stable(cur_addr));

  // R11
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (fb_addr[3:0] == 4'h0 && cb_addr[3:0] == 4'h0));
endmodule

bind disp_scan_agen scan_agen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .frame_start (frame_start),
  .line_start  (line_start),
  .fb_req      (fb_req),
  .fb_addr     (fb_addr),
  .fb_pix_off  (fb_pix_off),
  .fb_done     (fb_done),
  .cb_req      (cb_req),
  .cb_addr     (cb_addr),
  .cb_done     (cb_done),
  .cur_req     (cur_req),
  .cur_addr    (cur_addr),
  .comp_off    (comp_off)
);

// File: tb/sim_disp_scan_agen.sv
`timescale 1ns/1ps
module sim_disp_scan_agen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        frame_start, line_start;
  logic        fb_req, cb_req, cur_req;
  logic [21:0] fb_addr, cb_addr, cur_addr;
  logic [3:0]  fb_pix_off;
  logic        fb_done, cb_done, comp_off;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  disp_scan_agen u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_start(frame_start), .line_start(line_start),
    .fb_req(fb_req), .fb_addr(fb_addr), .fb_pix_off(fb_pix_off), .fb_done(fb_done),
    .cb_req(cb_req), .cb_addr(cb_addr), .cb_done(cb_done),
    .cur_req(cur_req), .cur_addr(cur_addr), .comp_off(comp_off)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pulse(input bit f, input bit l);
    @(negedge clk);
    frame_start = f; line_start = l;
    @(negedge clk);
    frame_start = 1'b0; line_start = 1'b0;
  endtask

  task automatic fetch(input int which, input int n);
    @(negedge clk);
    if (which == 0) fb_req = 1'b1;
    else if (which == 1) cb_req = 1'b1;
    else cur_req = 1'b1;
    repeat (n) @(negedge clk);
    fb_req = 1'b0; cb_req = 1'b0; cur_req = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R10 fb_addr", 32'(fb_addr), 0);
    check("R10 fb_done", 32'(fb_done), 1);
    check("R10 cb_done", 32'(cb_done), 1);
    check("R10 cur_addr", 32'(cur_addr), 0);
    check("R10 comp_off", 32'(comp_off), 0);
    check("R10 pix", 32'(fb_pix_off), 0);
    rd(3'd0, d); check("R10 reg0", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); check("R1 fb start read", d, 32'h003F_FFFF);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); check("R6 cb start read", d, 32'h003F_FFF0);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d); check("R7 cur start read", d, 32'h003F_FFFC);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); check("R1 step read", d, 32'h003F_F3FF);
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, d); check("R1 budget read", d, 32'h003F_F3FF);
    rd(3'd5, d); check("R1 idx5 read", d, 0);
    rd(3'd7, d); check("R1 idx7 read", d, 0);
    check("R8 comp_off set", 32'(comp_off), 1);
  endtask

  task automatic t_lines;
    wr(3'd0, 32'h0000_1000);
    wr(3'd3, (32'd7 << 12) | 32'd100);
    wr(3'd4, (32'd2 << 12) | 32'd3);
    pulse(1, 0);
    check("R2 fb frame load", 32'(fb_addr), 32'h1000);
    check("R5 fb not done", 32'(fb_done), 0);
    fetch(0, 3);
    check("R5 fb after 3", 32'(fb_addr), 32'h100C);
    check("R5 fb done", 32'(fb_done), 1);
    fetch(0, 2);
    check("R5 fb ignored req", 32'(fb_addr), 32'h100C);
    pulse(0, 1);
    check("R4 fb line step", 32'(fb_addr), 32'h1190);
    check("R4 fb index reset", 32'(fb_done), 0);
    pulse(1, 1);
    check("R11 frame wins", 32'(fb_addr), 32'h1000);
  endtask

  task automatic t_shadow;
    wr(3'd0, 32'h0002_0005);
    check("R3 pix immediate", 32'(fb_pix_off), 5);
    check("R2 no early move", 32'(fb_addr), 32'h1000);
    pulse(0, 1);
    check("R2 line uses old", 32'(fb_addr), 32'h1190);
    pulse(1, 0);
    check("R2 frame applies", 32'(fb_addr), 32'h2_0000);
    check("R3 pix kept", 32'(fb_pix_off), 5);
  endtask

  task automatic t_cb;
    logic [31:0] d;
    wr(3'd1, 32'h0000_200F);
    rd(3'd1, d); check("R6 cb low bits drop", d, 32'h2000);
    pulse(1, 0);
    check("R6 cb frame load", 32'(cb_addr), 32'h2000);
    fetch(1, 2);
    check("R5 cb after 2", 32'(cb_addr), 32'h2008);
    check("R5 cb done", 32'(cb_done), 1);
    pulse(0, 1);
    check("R4 cb line step", 32'(cb_addr), 32'h201C);
    check("R4 cb not done", 32'(cb_done), 0);
  endtask

  task automatic t_cursor;
    logic [31:0] d;
    wr(3'd2, 32'h0000_0303);
    rd(3'd2, d); check("R7 cur aligned read", d, 32'h300);
    pulse(1, 0);
    check("R7 cur load", 32'(cur_addr), 32'h300);
    fetch(2, 2);
    check("R7 cur linear", 32'(cur_addr), 32'h308);
    pulse(0, 1);
    check("R7 cur no line step", 32'(cur_addr), 32'h308);
    pulse(1, 0);
    check("R7 cur reload", 32'(cur_addr), 32'h300);
  endtask

  task automatic t_wrap;
    wr(3'd0, 32'h003F_FFF0);
    wr(3'd3, 32'd8);
    wr(3'd4, 32'd8);
    pulse(1, 0);
    check("R9 near top", 32'(fb_addr), 32'h3F_FFF0);
    fetch(0, 4);
    check("R9 fetch wrap", 32'(fb_addr), 32'h0);
    pulse(0, 1);
    check("R9 line wrap", 32'(fb_addr), 32'h10);
  endtask

  task automatic t_comp;
    check("R8 comp on", 32'(comp_off), 1);
    wr(3'd0, 32'h0);
    check("R8 comp off", 32'(comp_off), 0);
    check("R3 pix zero", 32'(fb_pix_off), 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    frame_start = 1'b0; line_start = 1'b0;
    fb_req = 1'b0; cb_req = 1'b0; cur_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_lines();
    t_shadow();
    t_cb();
    t_cursor();
    t_wrap();
    t_comp();
    finish_run();
  end
endmodule